// File: doc/BRIEF.md
# Processor Trace Status Encoder

This block watches a core's execution events and emits two 4-bit streams for an external debug probe. One is a processor-status code (`pst_o`), updated every clock. The other is a data nibble (`ddata_o`). Instruction completion, taken branches and exception handling each produce a status code. Selected 32-bit values are captured into a small FIFO: stack-frame writes, vector reads, branch targets and operand transfers. Each value is announced by a start-of-data marker on `pst_o` and is then shifted out on `ddata_o`, least-significant nibble first.

A configuration word decides which operands are shown, and some transfers are always filtered out. Automatic line-sized move-multiple bursts are never captured. Jump targets are shown only for addressing modes whose target is computed at run time. While exception processing runs, the status output holds a dedicated code, and only a data marker or the taken-branch code can replace it. A branch target is shortened according to how many of its upper bytes changed since the last reported target.

Top module: `trc_encoder`

## Requirements
- R1: After reset, `pst_o`=0x0, `ddata_o`=0x0 and `ovf_o`=0. With no event and nothing being sent, both streams read 0x0. All outputs are registered: an event sampled at clock edge k shows on the outputs after edge k.
- R2: Outside exception processing, an `insn_done_i` strobe without a branch gives `pst_o`=0x1 after that edge.
- R3: A `br_taken_i` strobe gives `pst_o`=0x5 after that edge, whatever else is strobed in the same cycle. The strobe also ends exception processing, so the following idle cycles read 0x0.
- R4: From the `exc_start_i` edge until the branch that ends it, every cycle reads 0xC on `pst_o`, unless a data marker or 0x5 is output in that cycle. This holds even when `insn_done_i` is strobed.
- R5: During a normal exception (`exc_reset_i`=0 at start), each `frame_wr_i` and `vec_rd_i` strobe captures `xfer_data_i` with marker 0xB, sent as 8 nibbles.
- R6: During a reset exception (`exc_reset_i`=1 at start), `frame_wr_i` and `vec_rd_i` strobes capture nothing.
- R7: `br_mode_i` encodes the addressing mode: 0 absolute short, 1 absolute long, 2 register indirect, 3 indirect with 16-bit displacement, 4 indexed with 8-bit displacement, 5 PC with 16-bit displacement, 6 PC indexed, 7 other. A target is captured only for modes 2, 3, 4 and 6, or for any mode while an exception is being processed.
- R8: A captured target is compared with the last captured target (0 after reset). If bits 31:24 differ, the marker is 0xB and 8 nibbles are sent. Otherwise, if bits 23:16 differ, the marker is 0xA and 6 nibbles are sent. Otherwise the marker is 0x9 and 4 nibbles are sent.
- R9: `opnd_kind_i` encodes the operand kind: 0 plain, 1 multiply-accumulate load, 2 predicted return, 3 move-multiple. Plain and move-multiple operands are captured (marker 0xB) only when `cfg_i[8]`=1. A move-multiple with `opnd_addr_lo_i`=0 and `movem_left_i`>=4 is a burst and is never captured, whatever `cfg_i` holds.
- R10: A predicted-return operand is captured only if `cfg_i[12]`, `cfg_i[9]` or `cfg_i[8]` is set.
- R11: A multiply-accumulate load operand is always captured, with marker 0xB.
- R12: A queued value starts in a cycle where the serializer is idle, the FIFO is not empty, and neither `br_taken_i` nor `insn_done_i` is strobed. In that cycle `pst_o` shows the marker and `ddata_o` shows nibble 0. The remaining nibbles follow in order, one per clock, and a following value may start in the very next cycle.
- R13: The FIFO holds `FIFO_DEPTH` values. A capture that arrives while the FIFO is full and is not popped in the same cycle is dropped, and `ovf_o` rises and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 16 | Display configuration word |
| insn_done_i | input | 1 | Instruction completed strobe |
| exc_start_i | input | 1 | Exception processing begins |
| exc_reset_i | input | 1 | Qualifies `exc_start_i` as a reset exception |
| frame_wr_i | input | 1 | Stack-frame write strobe |
| vec_rd_i | input | 1 | Vector read strobe |
| xfer_data_i | input | 32 | Data for frame, vector or operand transfers |
| br_taken_i | input | 1 | Taken branch or jump strobe |
| br_mode_i | input | 3 | Addressing mode of the jump |
| br_target_i | input | 32 | Branch target address |
| opnd_i | input | 1 | Operand transfer strobe |
| opnd_kind_i | input | 2 | Operand kind |
| opnd_addr_lo_i | input | 4 | Low nibble of operand address |
| movem_left_i | input | 5 | Registers remaining in a move-multiple |
| pst_o | output | 4 | Processor-status code |
| ddata_o | output | 4 | Debug data nibble |
| ovf_o | output | 1 | Sticky capture-drop flag |

## Verification
Every status code is due one edge after its strobe. The bench drives inputs just after a falling edge and reads `pst_o` at the next falling edge, so exactly one rising edge lies between them. A captured value first shows as a marker at least one edge after its push, and may wait longer behind earlier values or blocked slots. For this reason, a stream decoder running on every falling edge reassembles each marker and the nibbles that follow it. It compares the result in order with a queue of expected values, which the bench builds from the requirements. Any marker that appears when nothing is expected is reported as a failure, and this is how suppressed captures are checked. The overflow flag is sampled one edge after the fifth and the sixth back-to-back captures.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int DW    = 32;
  localparam int CFG_W = 16;
  localparam int MV_W  = 5;
  localparam int PST_W = 4;
  localparam int NIB   = DW / 4;
  localparam int NIB_W = $clog2(NIB);

  localparam logic [PST_W-1:0] PST_IDLE = 4'h0;
  localparam logic [PST_W-1:0] PST_INSN = 4'h1;
  localparam logic [PST_W-1:0] PST_BR   = 4'h5;
  localparam logic [PST_W-1:0] PST_EXC  = 4'hC;
  localparam logic [PST_W-1:0] MK_2B    = 4'h9;
  localparam logic [PST_W-1:0] MK_3B    = 4'hA;
  localparam logic [PST_W-1:0] MK_4B    = 4'hB;

  typedef enum logic [1:0] {
    OPK_PLAIN = 2'd0, OPK_MAC = 2'd1, OPK_RTS = 2'd2, OPK_MOVEM = 2'd3
  } opk_t;

  typedef enum logic [2:0] {
    EA_ABS_W = 3'd0, EA_ABS_L = 3'd1, EA_IND = 3'd2, EA_D16 = 3'd3,
    EA_IDX8 = 3'd4, EA_PC_D16 = 3'd5, EA_PC_IDX = 3'd6, EA_OTHER = 3'd7
  } ea_t;

  typedef struct packed {
    logic [PST_W-1:0] mark;
    logic [DW-1:0]    val;
  } item_t;

  // modes whose target is computed at run time
  function automatic logic ea_shows(ea_t m);
    return (m == EA_IND) || (m == EA_D16) || (m == EA_IDX8) || (m == EA_PC_IDX);
  endfunction

  function automatic logic [PST_W-1:0] target_mark(logic [DW-1:0] a, logic [DW-1:0] prev);
    if (a[DW-1 -: 8] != prev[DW-1 -: 8]) return MK_4B;
    if (a[DW-9 -: 8] != prev[DW-9 -: 8]) return MK_3B;
    return MK_2B;
  endfunction

  function automatic logic [NIB_W:0] mark_nibbles(logic [PST_W-1:0] mk);
    case (mk)
      MK_2B:   return (NIB_W+1)'(4);
      MK_3B:   return (NIB_W+1)'(6);
      default: return (NIB_W+1)'(NIB);
    endcase
  endfunction

  function automatic logic is_burst(logic [3:0] addr_lo, logic [MV_W-1:0] left);
    return (addr_lo == 4'h0) && (left >= MV_W'(4));
  endfunction

  function automatic logic opnd_shows(opk_t k, logic [CFG_W-1:0] cfg, logic burst);
    case (k)
      OPK_MAC:   return 1'b1;
      OPK_RTS:   return cfg[12] | cfg[9] | cfg[8];
      OPK_MOVEM: return cfg[8] & ~burst;
      default:   return cfg[8];
    endcase
  endfunction
endpackage

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             exc_start_i,
  input  logic             exc_reset_i,
  input  logic             frame_wr_i,
  input  logic             vec_rd_i,
  input  logic [DW-1:0]    xfer_data_i,
  input  logic             br_taken_i,
  input  logic [2:0]       br_mode_i,
  input  logic [DW-1:0]    br_target_i,
  input  logic             opnd_i,
  input  logic [1:0]       opnd_kind_i,
  input  logic [3:0]       opnd_addr_lo_i,
  input  logic [MV_W-1:0]  movem_left_i,
  output logic             exc_busy_o,
  output logic             burst_o,
  output logic             push_o,
  output item_t            item_o
);
  logic          exc_q, exc_rst_q;
  logic [DW-1:0] last_q;
  logic          frame_cap, vec_cap, br_cap, op_cap;

  assign burst_o   = opnd_i && (opk_t'(opnd_kind_i) == OPK_MOVEM)
                     && is_burst(opnd_addr_lo_i, movem_left_i);
  assign frame_cap = frame_wr_i && exc_q && !exc_rst_q;
  assign vec_cap   = vec_rd_i && exc_q && !exc_rst_q;
  assign br_cap    = br_taken_i && (ea_shows(ea_t'(br_mode_i)) || exc_q);
  assign op_cap    = opnd_i && opnd_shows(opk_t'(opnd_kind_i), cfg_i, burst_o);
  assign exc_busy_o = exc_q || exc_start_i;

  always_comb begin
    push_o = 1'b0;
    item_o = '0;
    if (frame_cap) begin
      push_o = 1'b1;
      item_o = '{mark: MK_4B, val: xfer_data_i};
    end else if (vec_cap) begin
      push_o = 1'b1;
      item_o = '{mark: MK_4B, val: xfer_data_i};
    end else if (br_cap) begin
      push_o = 1'b1;
      item_o = '{mark: target_mark(br_target_i, last_q), val: br_target_i};
    end else if (op_cap) begin
      push_o = 1'b1;
      item_o = '{mark: MK_4B, val: xfer_data_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q     <= 1'b0;
      exc_rst_q <= 1'b0;
      last_q    <= '0;
    end else begin
      if (br_taken_i) begin
        exc_q     <= 1'b0;
        exc_rst_q <= 1'b0;
      end else if (exc_start_i) begin
        exc_q     <= 1'b1;
        exc_rst_q <= exc_reset_i;
      end
      if (br_cap) last_q <= br_target_i;
    end
  end
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_pop, do_push;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign drop_o  = push_i && !do_push;
  assign rdata_o = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/trc_serial.sv
module trc_serial
  import trc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_taken_i,
  input  logic             insn_done_i,
  input  logic             exc_busy_i,
  input  logic             empty_i,
  input  item_t            head_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic [PST_W-1:0] pst_o,
  output logic [3:0]       ddata_o
);
  logic [NIB_W-1:0] cnt_q;
  logic [DW-5:0]    sh_q;

  assign busy_o = (cnt_q != '0);
  assign pop_o  = !busy_o && !empty_i && !br_taken_i && !insn_done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst_o   <= PST_IDLE;
      ddata_o <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      if (br_taken_i)      pst_o <= PST_BR;
      else if (pop_o)      pst_o <= head_i.mark;
      else if (exc_busy_i) pst_o <= PST_EXC;
      else if (insn_done_i) pst_o <= PST_INSN;
      else                 pst_o <= PST_IDLE;

      if (pop_o) begin
        ddata_o <= head_i.val[3:0];
        sh_q    <= head_i.val[DW-1:4];
        cnt_q   <= NIB_W'(mark_nibbles(head_i.mark) - 1'b1);
      end else if (busy_o) begin
        ddata_o <= sh_q[3:0];
        sh_q    <= sh_q >> 4;
        cnt_q   <= cnt_q - 1'b1;
      end else begin
        ddata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/trc_encoder.sv
module trc_encoder
  import trc_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_i,
  input  logic        insn_done_i,
  input  logic        exc_start_i,
  input  logic        exc_reset_i,
  input  logic        frame_wr_i,
  input  logic        vec_rd_i,
  input  logic [31:0] xfer_data_i,
  input  logic        br_taken_i,
  input  logic [2:0]  br_mode_i,
  input  logic [31:0] br_target_i,
  input  logic        opnd_i,
  input  logic [1:0]  opnd_kind_i,
  input  logic [3:0]  opnd_addr_lo_i,
  input  logic [4:0]  movem_left_i,
  output logic [3:0]  pst_o,
  output logic [3:0]  ddata_o,
  output logic        ovf_o
);
  localparam int IW = $bits(item_t);

  logic          exc_busy, burst, push, pop, empty, full, drop, ser_busy;
  item_t         push_item, head;
  logic [IW-1:0] fifo_rd;
  logic          ovf_q;
  logic          unused_cfg;

  assign unused_cfg = ^{cfg_i[15:13], cfg_i[11:10], cfg_i[7:0]};

  trc_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
    .exc_start_i(exc_start_i), .exc_reset_i(exc_reset_i),
    .frame_wr_i(frame_wr_i), .vec_rd_i(vec_rd_i), .xfer_data_i(xfer_data_i),
    .br_taken_i(br_taken_i), .br_mode_i(br_mode_i), .br_target_i(br_target_i),
    .opnd_i(opnd_i), .opnd_kind_i(opnd_kind_i), .opnd_addr_lo_i(opnd_addr_lo_i),
    .movem_left_i(movem_left_i),
    .exc_busy_o(exc_busy), .burst_o(burst), .push_o(push), .item_o(push_item)
  );

  trc_fifo #(.DEPTH(FIFO_DEPTH), .W(IW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .wdata_i(push_item),
    .rdata_o(fifo_rd), .empty_o(empty), .full_o(full), .drop_o(drop)
  );

  assign head = fifo_rd;

  trc_serial u_ser (
    .clk(clk), .rst_n(rst_n), .br_taken_i(br_taken_i), .insn_done_i(insn_done_i),
    .exc_busy_i(exc_busy), .empty_i(empty), .head_i(head),
    .pop_o(pop), .busy_o(ser_busy), .pst_o(pst_o), .ddata_o(ddata_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end
  assign ovf_o = ovf_q;
endmodule

// File: rtl/trc_encoder_chk.sv
module trc_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_done_i,
  input logic       br_taken_i,
  input logic       frame_wr_i,
  input logic       vec_rd_i,
  input logic [3:0] pst_o,
  input logic [3:0] ddata_o,
  input logic       ovf_o,
  input logic       exc_busy,
  input logic       burst,
  input logic       push,
  input logic       pop,
  input logic       full,
  input logic       drop,
  input logic       ser_busy
);
  // R1
  quiet_pst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_busy && !br_taken_i && !insn_done_i && !pop) |=> (pst_o == 4'h0));
  // R1
  quiet_dd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_busy && !pop) |=> (ddata_o == 4'h0));
  // R2
  insn_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done_i && !br_taken_i && !exc_busy) |=> (pst_o == 4'h1));
  // R3
  branch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_i |=> (pst_o == 4'h5));
  // R4
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_busy && !br_taken_i && !pop) |=> (pst_o == 4'hC));
  // R9
  burst_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !frame_wr_i && !vec_rd_i && !br_taken_i) |-> !push);
  // R12
  marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (pst_o == 4'h9 || pst_o == 4'hA || pst_o == 4'hB));
  // R13
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> full);
  // R13
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_o);
  // R13
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
endmodule

bind trc_encoder trc_encoder_chk u_chk (.*);

// File: tb/sim_trc_encoder.sv
module sim_trc_encoder;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg = '0;
  logic        insn = 0, exc_s = 0, exc_r = 0, frame = 0, vec = 0, br = 0, opnd = 0;
  logic [31:0] xdata = '0, tgt = '0;
  logic [2:0]  mode = '0;
  logic [1:0]  kind = '0;
  logic [3:0]  alo = '0;
  logic [4:0]  left = '0;
  logic [3:0]  pst, dd;
  logic        ovf;

  always #10 clk = ~clk;

  trc_encoder #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .insn_done_i(insn),
    .exc_start_i(exc_s), .exc_reset_i(exc_r), .frame_wr_i(frame), .vec_rd_i(vec),
    .xfer_data_i(xdata), .br_taken_i(br), .br_mode_i(mode), .br_target_i(tgt),
    .opnd_i(opnd), .opnd_kind_i(kind), .opnd_addr_lo_i(alo), .movem_left_i(left),
    .pst_o(pst), .ddata_o(dd), .ovf_o(ovf)
  );

  int total = 0, bad = 0;
  logic [35:0] expq[$];
  string       expr[$];
  logic [31:0] b_last = '0;

  task automatic chk(string r, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic bit b_variant(logic [2:0] m);
    case (m)
      3'd2, 3'd3, 3'd4, 3'd6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] b_mark(logic [31:0] a, logic [31:0] p);
    int nb = 2;
    for (int i = 2; i <= 3; i++) if (a[8*i +: 8] != p[8*i +: 8]) nb = i + 1;
    return (nb == 4) ? 4'hB : (nb == 3) ? 4'hA : 4'h9;
  endfunction

  function automatic int b_len(logic [3:0] mk);
    return (mk == 4'h9) ? 4 : (mk == 4'hA) ? 6 : 8;
  endfunction

  function automatic bit b_op_shown(int k, logic [15:0] c, logic [3:0] lo, logic [4:0] n);
    bit burst = (lo == 4'd0) && (n >= 5'd4);
    case (k)
      0: return c[8];
      1: return 1'b1;
      2: return c[8] || c[9] || c[12];
      default: return c[8] && !burst;
    endcase
  endfunction

  task automatic exp_item(string r, logic [3:0] mk, logic [31:0] v);
    int n = b_len(mk);
    logic [31:0] m = (n == 8) ? 32'hFFFF_FFFF : ((32'h1 << (4*n)) - 1);
    expq.push_back({mk, v & m});
    expr.push_back(r);
  endtask

  // stream decoder: marker on pst, then nibbles on ddata, LS first (R12)
  int          need = 0, idx = 0;
  logic [31:0] acc = '0;
  logic [3:0]  mk_seen = '0;

  task automatic close_item();
    if (expq.size() == 0) begin
      chk("R12 unexpected item", {mk_seen, acc}, 36'h0);
    end else begin
      logic [35:0] e = expq.pop_front();
      string r = expr.pop_front();
      chk(r, {mk_seen, acc}, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (idx < need) begin
        acc[4*idx +: 4] = dd;
        idx++;
        if (idx == need) close_item();
      end else if (pst == 4'h9 || pst == 4'hA || pst == 4'hB) begin
        mk_seen = pst;
        need = b_len(pst);
        acc = '0;
        acc[3:0] = dd;
        idx = 1;
        if (need == 1) close_item();
      end
    end
  end

  task automatic clr();
    insn = 0; exc_s = 0; exc_r = 0; frame = 0; vec = 0; br = 0; opnd = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drain(string r);
    for (int i = 0; i < 200 && expq.size() != 0; i++) step();
    repeat (12) step();
    chk(r, 36'(expq.size()), 36'h0);
  endtask

  task automatic do_branch(logic [2:0] m, logic [31:0] t, bit in_exc, bit with_insn, string r);
    br = 1; mode = m; tgt = t; insn = with_insn;
    if (b_variant(m) || in_exc) begin
      exp_item(r, b_mark(t, b_last), t);
      b_last = t;
    end
    step();
    chk("R3 branch code", 36'(pst), 36'h5);
    clr();
  endtask

  task automatic do_opnd(int k, logic [31:0] d, logic [3:0] lo, logic [4:0] n);
    string r = (k == 1) ? "R11" : (k == 2) ? "R10" : "R9";
    opnd = 1; kind = 2'(k); xdata = d; alo = lo; left = n;
    if (b_op_shown(k, cfg, lo, n)) exp_item(r, 4'hB, d);
    step();
    clr();
  endtask

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd1234);
    seed = seed;
    repeat (3) step();
    chk("R1 reset pst", 36'(pst), 36'h0);
    rst_n = 1;
    step();
    chk("R1 idle pst", 36'(pst), 36'h0);
    chk("R1 idle ddata", 36'(dd), 36'h0);
    chk("R1 ovf", 36'(ovf), 36'h0);

    // R2 instruction completion
    insn = 1; step(); chk("R2 insn", 36'(pst), 36'h1); clr();
    step(); chk("R1 back to idle", 36'(pst), 36'h0);

    // R7 / R8 target display and marker sizing
    do_branch(3'd2, 32'h0000_1234, 0, 0, "R8 two bytes");     drain("R8");
    do_branch(3'd3, 32'h0056_789A, 0, 0, "R8 three bytes");   drain("R8");
    do_branch(3'd4, 32'h1200_0000, 0, 0, "R8 four bytes");    drain("R8");
    do_branch(3'd0, 32'hFFFF_FFFF, 0, 0, "R7 absolute");      drain("R7 not shown");
    do_branch(3'd5, 32'hEEEE_0000, 0, 0, "R7 pc disp16");     drain("R7 not shown");
    do_branch(3'd6, 32'h1200_00FF, 0, 1, "R7 pc indexed");    drain("R7");

    // R9 / R10 / R11 operand filtering
    cfg = 16'h0000; do_opnd(0, 32'hAAAA_0001, 4'h4, 5'd0); drain("R9 plain off");
    cfg = 16'h0100; do_opnd(0, 32'hAAAA_0002, 4'h4, 5'd0); drain("R9 plain on");
    cfg = 16'h0000; do_opnd(1, 32'hBBBB_0003, 4'h0, 5'd0); drain("R11 mac");
    cfg = 16'h1000; do_opnd(2, 32'hCCCC_0004, 4'h0, 5'd0); drain("R10 bit12");
    cfg = 16'h0200; do_opnd(2, 32'hCCCC_0005, 4'h0, 5'd0); drain("R10 bit9");
    cfg = 16'h0400; do_opnd(2, 32'hCCCC_0006, 4'h0, 5'd0); drain("R10 other bit");
    cfg = 16'h0100; do_opnd(3, 32'hDDDD_0007, 4'h0, 5'd4); drain("R9 burst");
    cfg = 16'h0100; do_opnd(3, 32'hDDDD_0008, 4'h0, 5'd3); drain("R9 three left");
    cfg = 16'h0100; do_opnd(3, 32'hDDDD_0009, 4'h4, 5'd8); drain("R9 unaligned");
    cfg = 16'hFFFF; do_opnd(3, 32'hDDDD_000A, 4'h0, 5'd16); drain("R9 burst all cfg");

    // R4 / R5 normal exception
    exc_s = 1; step(); chk("R4 exc start", 36'(pst), 36'hC); clr();
    frame = 1; xdata = 32'hF1F1_0001; exp_item("R5 frame", 4'hB, xdata);
    step(); chk("R4 frame cycle", 36'(pst), 36'hC); clr();
    frame = 1; xdata = 32'hF2F2_0002; exp_item("R5 frame", 4'hB, xdata);
    step(); chk("R12 marker during exc", 36'(pst), 36'hB); clr();
    vec = 1; xdata = 32'h0000_0100; exp_item("R5 vector", 4'hB, xdata);
    step(); chk("R4 vector cycle", 36'(pst), 36'hC); clr();
    insn = 1; step(); chk("R4 insn in exc", 36'(pst), 36'hC); clr();
    for (int i = 0; i < 3; i++) begin step(); chk("R4 hold", 36'(pst), 36'hC); end
    do_branch(3'd0, 32'h0000_4000, 1, 0, "R7 handler");
    drain("R5");
    chk("R3 exc ended", 36'(pst), 36'h0);

    // R6 reset exception
    exc_s = 1; exc_r = 1; step(); chk("R4 reset exc", 36'(pst), 36'hC); clr();
    frame = 1; xdata = 32'h1111_1111; step(); chk("R6 frame", 36'(pst), 36'hC); clr();
    vec = 1; xdata = 32'h2222_2222; step(); chk("R6 vector", 36'(pst), 36'hC); clr();
    step(); chk("R4 reset hold", 36'(pst), 36'hC);
    do_branch(3'd1, 32'h0000_0400, 1, 0, "R6 handler");
    drain("R6");

    // random mix (R2 R3 R7 R8 R9 R10 R11 R12)
    for (int it = 0; it < 200; it++) begin
      case ($urandom % 4)
        0: cfg = 16'h0000;
        1: cfg = 16'h0100;
        2: cfg = 16'h1000;
        default: cfg = 16'($urandom);
      endcase
      if ($urandom % 2) begin
        logic [31:0] t = b_last;
        int r = $urandom % 3;
        t[15:0] = 16'($urandom);
        if (r >= 1) t[23:16] = t[23:16] ^ 8'(($urandom % 255) + 1);
        if (r == 2) t[31:24] = t[31:24] ^ 8'(($urandom % 255) + 1);
        do_branch(3'($urandom), t, 0, bit'($urandom % 2), "R8 random target");
      end else begin
        logic [3:0] lo = 4'($urandom);
        if ($urandom % 2) lo = 4'h0;
        do_opnd($urandom % 4, $urandom, lo, 5'($urandom % 8));
      end
      for (int f = 0; f < 11; f++) begin
        insn = ($urandom % 3) == 0;
        step();
        if (insn) chk("R2 random insn", 36'(pst), 36'h1);
        clr();
      end
    end
    drain("R12 random");
    chk("R13 no overflow in mix", 36'(ovf), 36'h0);

    // R13 overflow
    cfg = 16'h0100;
    for (int i = 0; i < DEPTH + 2; i++) begin
      opnd = 1; kind = 2'd0; xdata = 32'h5000_0000 + 32'(i);
      if (i <= DEPTH) exp_item("R13 kept", 4'hB, xdata);
      step(); clr();
      if (i == DEPTH)     chk("R13 not yet", 36'(ovf), 36'h0);
      if (i == DEPTH + 1) chk("R13 raised", 36'(ovf), 36'h1);
    end
    drain("R13");
    chk("R13 sticky", 36'(ovf), 36'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule